// File: doc/BRIEF.md
# Reverse-Subtract Form Decoder

This block sits in the front end of a stack-based floating-point unit. It takes the opcode byte and the addressing byte (ModR/M) of one instruction and works out whether the pair is one of the reverse-subtract forms. A reverse subtract computes "source minus destination". When the pair is one of these forms, the block reports four things:

- which operand is the minuend and which is the subtrahend, each being either memory or a stack slot;
- the stack slot that receives the difference;
- the format of the memory operand and whether it is an integer that must be converted first;
- whether the register stack is popped afterwards.

Any other byte pair is reported as illegal. The block does no address generation, no arithmetic and holds no register file.

The input is a byte pair qualified by `in_valid`. Each accepted pair produces one registered result with `out_valid` exactly one cycle later. The block has no ready signal and applies no back-pressure: it accepts a new pair on every cycle, so the consumer must take every result in the cycle it appears. Between results the output fields keep their last value, and they carry meaning only while `out_valid` is high.

Top module: `rsub_form_decoder`

## Requirements
- R1: Opcode 0xD8 with a memory addressing byte (mod field bits [7:6] not equal to 3) and reg field bits [5:3] equal to 5 decodes as minuend = memory (source code 2), subtrahend = stack (source code 1) slot 0, destination slot 0, memory format 1 (32-bit real), no integer convert, no pop.
- R2: Opcode 0xDC in the same memory form decodes as R1 but with memory format 2 (64-bit real).
- R3: Opcode 0xDA and opcode 0xDE in the memory form with reg field 5 decode as R1 but with memory format 3 (32-bit integer) and 4 (16-bit integer) respectively, and with the integer-convert flag set.
- R4: Opcode 0xD8 with second byte 0xE8+i (mod 3, reg 5, i in bits [2:0]) gives minuend = stack slot i, subtrahend = stack slot 0, destination slot 0, memory format 0, no pop.
- R5: Opcode 0xDC with second byte 0xE0+i (mod 3, reg 4) gives minuend = stack slot 0, subtrahend = stack slot i, destination slot i, no pop.
- R6: Opcode 0xDE with second byte 0xE0+i gives the R5 fields with pop set. This includes 0xDE 0xE1, the implicit form with slot 1.
- R7: A memory form is recognised only when mod is not 3 and reg is 5. Any other reg value in a memory form is illegal, and memory format is nonzero exactly when the minuend is memory.
- R8: Every byte pair not covered by R1–R6 raises `out_illegal` and drives every other decode output to zero (source code 0 = none).
- R9: `out_valid` equals `in_valid` of the previous cycle, and reset clears `out_valid` and all decode outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte pair present this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_modrm | input | 8 | Addressing byte following the opcode |
| out_valid | output | 1 | Decode result present |
| out_illegal | output | 1 | Pair is not a reverse-subtract form |
| out_min_src | output | 2 | Minuend source: 0 none, 1 stack, 2 memory |
| out_min_idx | output | 3 | Minuend stack slot |
| out_sub_src | output | 2 | Subtrahend source: 0 none, 1 stack, 2 memory |
| out_sub_idx | output | 3 | Subtrahend stack slot |
| out_dst_idx | output | 3 | Destination stack slot |
| out_mem_fmt | output | 3 | 0 none, 1 real32, 2 real64, 3 int32, 4 int16 |
| out_int_cvt | output | 1 | Memory integer must be converted before subtracting |
| out_pop | output | 1 | Pop the register stack after writing |

## Verification
The bench builds the decoder with its default parameters: the four family opcode values and the reg-field extensions 5 and 4. With these defaults, every one of the 256 second-byte values can be swept for each family opcode and for several opcodes outside the family. That sweep reaches every stack slot index in each register form, including the implicit slot-1 popping form. It also reaches every mod value on the memory side and every reg value that must be rejected. Idle cycles are placed between beats, so that the one-cycle latency and the absence of spurious results are observed at the ports.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  localparam int IDX_W = 3;
  localparam int SRC_W = 2;
  localparam int FMT_W = 3;

  localparam logic [SRC_W-1:0] SRC_NONE = 2'd0;
  localparam logic [SRC_W-1:0] SRC_STK  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_MEM  = 2'd2;

  localparam logic [FMT_W-1:0] FMT_NONE = 3'd0;
  localparam logic [FMT_W-1:0] FMT_R32  = 3'd1;
  localparam logic [FMT_W-1:0] FMT_R64  = 3'd2;
  localparam logic [FMT_W-1:0] FMT_I32  = 3'd3;
  localparam logic [FMT_W-1:0] FMT_I16  = 3'd4;

  // form vector positions; the four memory forms come first
  localparam int N_MEMFORM   = 4;
  localparam int FRM_STI_ST0 = 4;  // slot i minus slot 0 -> slot 0
  localparam int FRM_ST0_STI = 5;  // slot 0 minus slot i -> slot i
  localparam int FRM_POPFORM = 6;  // as above, then pop
  localparam int N_FORM      = 7;

  typedef struct packed {
    logic             illegal;
    logic [SRC_W-1:0] min_src;
    logic [IDX_W-1:0] min_idx;
    logic [SRC_W-1:0] sub_src;
    logic [IDX_W-1:0] sub_idx;
    logic [IDX_W-1:0] dst_idx;
    logic [FMT_W-1:0] fmt;
    logic             int_cvt;
    logic             pop;
  } dec_t;
endpackage

// File: rtl/rsub_modrm_fields.sv
module rsub_modrm_fields
  import rsub_pkg::*;
(
  input  logic [7:0]       modrm,
  output logic [1:0]       mod_f,
  output logic [2:0]       reg_f,
  output logic [IDX_W-1:0] rm_f,
  output logic             is_mem
);
  always_comb begin
    mod_f  = modrm[7:6];
    reg_f  = modrm[5:3];
    rm_f   = modrm[IDX_W-1:0];
    is_mem = (modrm[7:6] != 2'b11);
  end
endmodule

// File: rtl/rsub_form_match.sv
module rsub_form_match
  import rsub_pkg::*;
#(
  parameter logic [7:0] OPC_R32   = 8'hD8,
  parameter logic [7:0] OPC_R64   = 8'hDC,
  parameter logic [7:0] OPC_I32   = 8'hDA,
  parameter logic [7:0] OPC_I16   = 8'hDE,
  parameter logic [2:0] EXT_MEM   = 3'd5,
  parameter logic [2:0] EXT_TOST0 = 3'd5,
  parameter logic [2:0] EXT_TOSTI = 3'd4
) (
  input  logic [7:0]        opcode,
  input  logic              is_mem,
  input  logic [2:0]        reg_f,
  output logic [N_FORM-1:0] hit
);
  localparam logic [8*N_MEMFORM-1:0] MEM_OPCS = {OPC_I16, OPC_I32, OPC_R64, OPC_R32};

  for (genvar g = 0; g < N_MEMFORM; g++) begin : g_mem
    assign hit[g] = is_mem && (reg_f == EXT_MEM) && (opcode == MEM_OPCS[g*8 +: 8]);
  end

  assign hit[FRM_STI_ST0] = !is_mem && (reg_f == EXT_TOST0) && (opcode == OPC_R32);
  assign hit[FRM_ST0_STI] = !is_mem && (reg_f == EXT_TOSTI) && (opcode == OPC_R64);
  assign hit[FRM_POPFORM] = !is_mem && (reg_f == EXT_TOSTI) && (opcode == OPC_I16);
endmodule

// File: rtl/rsub_field_build.sv
module rsub_field_build
  import rsub_pkg::*;
(
  input  logic [N_FORM-1:0] hit,
  input  logic [IDX_W-1:0]  rm_f,
  output dec_t              dec
);
  localparam logic [FMT_W*N_MEMFORM-1:0] FMT_TBL = {FMT_I16, FMT_I32, FMT_R64, FMT_R32};
  localparam logic [N_MEMFORM-1:0]       CVT_TBL = 4'b1100;

  logic [FMT_W-1:0] fmt_sel;
  logic             cvt_sel;

  always_comb begin
    fmt_sel = FMT_NONE;
    cvt_sel = 1'b0;
    for (int k = 0; k < N_MEMFORM; k++) begin
      if (hit[k]) begin
        fmt_sel = FMT_TBL[k*FMT_W +: FMT_W];
        cvt_sel = CVT_TBL[k];
      end
    end
  end

  always_comb begin
    dec = '0;
    if (|hit[N_MEMFORM-1:0]) begin
      dec.min_src = SRC_MEM;
      dec.sub_src = SRC_STK;
      dec.fmt     = fmt_sel;
      dec.int_cvt = cvt_sel;
    end else if (hit[FRM_STI_ST0]) begin
      dec.min_src = SRC_STK;
      dec.min_idx = rm_f;
      dec.sub_src = SRC_STK;
    end else if (hit[FRM_ST0_STI] || hit[FRM_POPFORM]) begin
      dec.min_src = SRC_STK;
      dec.sub_src = SRC_STK;
      dec.sub_idx = rm_f;
      dec.dst_idx = rm_f;
      dec.pop     = hit[FRM_POPFORM];
    end else begin
      dec.illegal = 1'b1;
    end
  end
endmodule

// File: rtl/rsub_out_stage.sv
module rsub_out_stage
  import rsub_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  dec_t d,
  output logic out_valid,
  output dec_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end
endmodule

// File: rtl/rsub_form_decoder.sv
module rsub_form_decoder
  import rsub_pkg::*;
#(
  parameter logic [7:0] OPC_R32   = 8'hD8,
  parameter logic [7:0] OPC_R64   = 8'hDC,
  parameter logic [7:0] OPC_I32   = 8'hDA,
  parameter logic [7:0] OPC_I16   = 8'hDE,
  parameter logic [2:0] EXT_MEM   = 3'd5,
  parameter logic [2:0] EXT_TOST0 = 3'd5,
  parameter logic [2:0] EXT_TOSTI = 3'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_opcode,
  input  logic [7:0]       in_modrm,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [SRC_W-1:0] out_min_src,
  output logic [IDX_W-1:0] out_min_idx,
  output logic [SRC_W-1:0] out_sub_src,
  output logic [IDX_W-1:0] out_sub_idx,
  output logic [IDX_W-1:0] out_dst_idx,
  output logic [FMT_W-1:0] out_mem_fmt,
  output logic             out_int_cvt,
  output logic             out_pop
);
  logic [1:0]        mod_f;
  logic [2:0]        reg_f;
  logic [IDX_W-1:0]  rm_f;
  logic              is_mem;
  logic [N_FORM-1:0] form_hit;
  dec_t              dec_c;
  dec_t              dec_q;

  rsub_modrm_fields i_fields (
    .modrm (in_modrm),
    .mod_f (mod_f),
    .reg_f (reg_f),
    .rm_f  (rm_f),
    .is_mem(is_mem)
  );

  rsub_form_match #(
    .OPC_R32  (OPC_R32),
    .OPC_R64  (OPC_R64),
    .OPC_I32  (OPC_I32),
    .OPC_I16  (OPC_I16),
    .EXT_MEM  (EXT_MEM),
    .EXT_TOST0(EXT_TOST0),
    .EXT_TOSTI(EXT_TOSTI)
  ) i_match (
    .opcode(in_opcode),
    .is_mem(is_mem),
    .reg_f (reg_f),
    .hit   (form_hit)
  );

  rsub_field_build i_build (
    .hit (form_hit),
    .rm_f(rm_f),
    .dec (dec_c)
  );

  rsub_out_stage i_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d        (dec_c),
    .out_valid(out_valid),
    .q        (dec_q)
  );

  assign out_illegal = dec_q.illegal;
  assign out_min_src = dec_q.min_src;
  assign out_min_idx = dec_q.min_idx;
  assign out_sub_src = dec_q.sub_src;
  assign out_sub_idx = dec_q.sub_idx;
  assign out_dst_idx = dec_q.dst_idx;
  assign out_mem_fmt = dec_q.fmt;
  assign out_int_cvt = dec_q.int_cvt;
  assign out_pop     = dec_q.pop;

  logic unused_mod;
  assign unused_mod = ^mod_f;
endmodule

// File: rtl/rsub_form_decoder_chk.sv
module rsub_form_decoder_chk
  import rsub_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_illegal,
  input logic [SRC_W-1:0] out_min_src,
  input logic [IDX_W-1:0] out_min_idx,
  input logic [SRC_W-1:0] out_sub_src,
  input logic [IDX_W-1:0] out_sub_idx,
  input logic [IDX_W-1:0] out_dst_idx,
  input logic [FMT_W-1:0] out_mem_fmt,
  input logic             out_int_cvt,
  input logic             out_pop,
  input logic [N_FORM-1:0] form_hit
);
  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R8
  illegal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_min_src == SRC_NONE && out_sub_src == SRC_NONE &&
      out_min_idx == '0 && out_sub_idx == '0 && out_dst_idx == '0 &&
      out_mem_fmt == FMT_NONE && !out_int_cvt && !out_pop));

  // R3
  int_convert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_int_cvt) |-> (out_min_src == SRC_MEM &&
      (out_mem_fmt == FMT_I32 || out_mem_fmt == FMT_I16)));

  // R6
  pop_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pop) |-> (out_min_src == SRC_STK && out_min_idx == '0 &&
      out_sub_src == SRC_STK && out_dst_idx == out_sub_idx));

  // R7
  fmt_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> ((out_min_src == SRC_MEM) == (out_mem_fmt != FMT_NONE)));

  // R7
  single_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(form_hit));
endmodule

bind rsub_form_decoder rsub_form_decoder_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_illegal(out_illegal),
  .out_min_src(out_min_src),
  .out_min_idx(out_min_idx),
  .out_sub_src(out_sub_src),
  .out_sub_idx(out_sub_idx),
  .out_dst_idx(out_dst_idx),
  .out_mem_fmt(out_mem_fmt),
  .out_int_cvt(out_int_cvt),
  .out_pop    (out_pop),
  .form_hit   (form_hit)
);

// File: tb/test_rsub_form_decoder.sv
`timescale 1ns/1ps
module test_rsub_form_decoder;
  import rsub_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_opcode = 8'h00;
  logic [7:0] in_modrm = 8'h00;
  logic out_valid, out_illegal, out_int_cvt, out_pop;
  logic [1:0] out_min_src, out_sub_src;
  logic [2:0] out_min_idx, out_sub_idx, out_dst_idx, out_mem_fmt;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  dec_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rsub_form_decoder i_rsub_form_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_opcode(in_opcode), .in_modrm(in_modrm),
    .out_valid(out_valid), .out_illegal(out_illegal),
    .out_min_src(out_min_src), .out_min_idx(out_min_idx),
    .out_sub_src(out_sub_src), .out_sub_idx(out_sub_idx),
    .out_dst_idx(out_dst_idx), .out_mem_fmt(out_mem_fmt),
    .out_int_cvt(out_int_cvt), .out_pop(out_pop)
  );

  // model written from the requirements
  function automatic void model(input logic [7:0] op, input logic [7:0] b,
                                output dec_t e, output string tag);
    logic [2:0] i;
    i = b[2:0];
    e = '0;
    e.illegal = 1'b1;
    tag = "R8";
    if (b[7:6] != 2'b11) begin
      tag = "R7";
      if (b[5:3] == 3'd5) begin
        dec_t m;
        m = '0;
        m.min_src = 2'd2;
        m.sub_src = 2'd1;
        case (op)
          8'hD8: begin m.fmt = 3'd1; e = m; tag = "R1"; end
          8'hDC: begin m.fmt = 3'd2; e = m; tag = "R2"; end
          8'hDA: begin m.fmt = 3'd3; m.int_cvt = 1'b1; e = m; tag = "R3"; end
          8'hDE: begin m.fmt = 3'd4; m.int_cvt = 1'b1; e = m; tag = "R3"; end
          default: tag = "R8";
        endcase
      end
    end else if (op == 8'hD8 && b[5:3] == 3'd5) begin
      e = '0; e.min_src = 2'd1; e.min_idx = i; e.sub_src = 2'd1; tag = "R4";
    end else if ((op == 8'hDC || op == 8'hDE) && b[5:3] == 3'd4) begin
      e = '0; e.min_src = 2'd1; e.sub_src = 2'd1; e.sub_idx = i; e.dst_idx = i;
      e.pop = (op == 8'hDE);
      tag = (op == 8'hDE) ? "R6" : "R5";
    end
  endfunction

  function automatic dec_t observed();
    dec_t g;
    g.illegal = out_illegal; g.min_src = out_min_src; g.min_idx = out_min_idx;
    g.sub_src = out_sub_src; g.sub_idx = out_sub_idx; g.dst_idx = out_dst_idx;
    g.fmt = out_mem_fmt; g.int_cvt = out_int_cvt; g.pop = out_pop;
    return g;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] b);
    dec_t e;
    string t;
    @(negedge clk);
    model(op, b, e, t);
    in_valid  = 1'b1;
    in_opcode = op;
    in_modrm  = b;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_opcode = 8'hDE;
      in_modrm  = 8'hE1;
    end
  endtask

  // monitor / scoreboard
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      if (out_valid) begin
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL R9: out_valid=1 with nothing expected (actual 1 expected 0)");
        end else begin
          dec_t e;
          dec_t g;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          g = observed();
          if (g !== e) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", t, g, e);
          end
        end
      end else if (exp_q.size() != 0) begin
        compared++;
        mismatched++;
        $display("FAIL R9: out_valid actual 0 expected 1");
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [9];
    int n;
    ops = '{8'hD8, 8'hDC, 8'hDA, 8'hDE, 8'hD9, 8'hDB, 8'hDD, 8'hDF, 8'h00};
    repeat (3) @(posedge clk);
    #2;
    // R9: reset state
    compared++;
    if (out_valid !== 1'b0 || observed() !== '0) begin
      mismatched++;
      $display("FAIL R9: reset actual valid=%b fields=%h expected 0/0", out_valid, observed());
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 R3 R4 R5 R6 R7 R8: full sweep of second byte per opcode
    n = 0;
    foreach (ops[j]) begin
      for (int b = 0; b < 256; b++) begin
        drive(ops[j], b[7:0]);
        n++;
        if (n % 5 == 0) idle(1 + (n % 3));
      end
    end
    // R6: implicit slot-1 popping form, back to back
    drive(8'hDE, 8'hE1);
    drive(8'hDE, 8'hE1);
    idle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule